// File: doc/BRIEF.md
# Multiplierless Sinc-Compensation FIR Filter

This block is an 11-tap constant-coefficient FIR filter in transposed form. It pre-distorts samples with a response close to x/sin(x), so that the droop of a zero-order-hold D/A converter is cancelled. There are no multipliers. Every coefficient is a canonical signed-digit value with at most two power-of-two terms, so each product is one or two shifted copies of the input, added or subtracted.

The 14-bit two's-complement input is sign-extended to a 16-bit internal word. That word is broadcast to all taps in the same cycle. The partial sums move down the tap delay chain as a separate sum vector and carry vector, and no carry is ever propagated. The block delivers the final pair unmerged: a separate adder downstream adds the two vectors into one word.

Samples enter through a valid/ready handshake. An accepted sample advances the tap chain by one step. A cycle with no accepted sample leaves the chain untouched. A fixed-depth output pipeline then presents each result a fixed number of cycles after its sample was accepted.

Top module: `csd_xsinx_fir`

## Requirements
- R1: While `rst` is high, `in_ready` is low and `out_valid` is low. From the first cycle after reset is released, `in_ready` is high.
- R2: A sample is accepted at a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` high after the 9th rising edge, counting the acceptance edge as the first. There is exactly one result per accepted sample, in acceptance order, and `out_valid` is low at every other time.
- R3: (`out_sum` + `out_carry`) mod 2^16 equals the sum over taps k = 0..10 of term(k, x[n-k]). Here x[n] is the newest accepted sample, and samples from before reset count as zero. For each CSD term, the input is sign-extended to 16 bits, arithmetically shifted right by the term's shift with truncation, and then added or subtracted. All arithmetic wraps modulo 2^16.
- R4: The coefficients for taps k are as follows:
  - k = 5: +2^0 + 2^-2.
  - k = 4 and 6: -2^-4 + 2^-8.
  - k = 3 and 7: +2^-6 + 2^-8.
  - k = 1 and 9: +2^-8.
  - k = 2 and 8: -2^-SH_INNER, default shift 7.
  - k = 0 and 10: -2^-SH_OUTER, default shift 9.
- R5: A cycle without an accepted sample leaves the tap chain unchanged. The result sequence with idle gaps equals the sequence without gaps.
- R6: The negative full-scale input -8192 is sign-extended correctly through every shifted term.
- R7: While `out_valid` is high, both output vectors carry defined values for arbitrary input sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 14 | Two's-complement input sample |
| out_valid | output | 1 | Result pair valid |
| out_sum | output | 16 | Sum vector of the result |
| out_carry | output | 16 | Carry vector of the result |

## Verification
Each result is due exactly nine rising edges after its acceptance edge. The bench records the edge number at which each sample will be accepted. It then requires, at the falling edge that follows the eighth edge after that, that `out_valid` is high and that the merged pair matches its reference value. A result that arrives early, late or unexpectedly is reported against R2. Idle gaps are inserted so that the same timing rule also checks that the chain holds between samples.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int DATA_W = 16;
    localparam int SH_W   = 5;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        word_t s;
        word_t c;
    } cs_pair_t;

    typedef struct packed {
        logic            en;
        logic            neg;
        logic [SH_W-1:0] sh;
    } term_t;

    // CSD term 'which' (0 or 1) of tap k; symmetric around the centre tap
    function automatic term_t coef_term(input int k, input int which,
                                        input int sh_outer, input int sh_inner);
        int    m;
        term_t t;
        m = (k > 5) ? 10 - k : k;
        t = '0;
        case (m)
            0: if (which == 0) t = '{1'b1, 1'b1, SH_W'(sh_outer)};
            1: if (which == 0) t = '{1'b1, 1'b0, SH_W'(8)};
            2: if (which == 0) t = '{1'b1, 1'b1, SH_W'(sh_inner)};
            3: t = (which == 0) ? '{1'b1, 1'b0, SH_W'(6)} : '{1'b1, 1'b0, SH_W'(8)};
            4: t = (which == 0) ? '{1'b1, 1'b1, SH_W'(4)} : '{1'b1, 1'b0, SH_W'(8)};
            default: t = (which == 0) ? '{1'b1, 1'b0, SH_W'(0)} : '{1'b1, 1'b0, SH_W'(2)};
        endcase
        return t;
    endfunction

    // shifted operand; a negative term is inverted here, its +1 goes in cin
    function automatic word_t term_operand(input word_t x, input term_t t);
        word_t sh;
        sh = word_t'($signed(x) >>> t.sh);
        if (!t.en)     return '0;
        else if (t.neg) return ~sh;
        else           return sh;
    endfunction

    // 3:2 compressor; the free LSB of the shifted carry takes cin
    function automatic cs_pair_t csa3(input word_t a, input word_t b,
                                      input word_t c, input logic cin);
        cs_pair_t r;
        word_t    maj;
        maj = (a & b) | (a & c) | (b & c);
        r.s = a ^ b ^ c;
        r.c = {maj[DATA_W-2:0], cin};
        return r;
    endfunction
endpackage

// File: rtl/csd_tap.sv
module csd_tap
    import fir_pkg::*;
#(
    parameter term_t TERM_A = '0,
    parameter term_t TERM_B = '0
) (
    input  word_t    x_word,
    input  cs_pair_t acc_in,
    output cs_pair_t acc_out
);
    cs_pair_t first;

    assign first = csa3(term_operand(x_word, TERM_A), acc_in.s, acc_in.c,
                        TERM_A.en & TERM_A.neg);

    generate
        if (TERM_B.en) begin : g_two_terms
            assign acc_out = csa3(term_operand(x_word, TERM_B), first.s, first.c,
                                  TERM_B.neg);
        end else begin : g_one_term
            assign acc_out = first;
        end
    endgenerate
endmodule

// File: rtl/fir_out_pipe.sv
module fir_out_pipe
    import fir_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  cs_pair_t in_data,
    output logic     out_valid,
    output cs_pair_t out_data
);
    logic     vld [DEPTH];
    cs_pair_t dat [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                vld[i] <= 1'b0;
                dat[i] <= '0;
            end else if (i == 0) begin
                vld[i] <= in_valid;
                if (in_valid) dat[i] <= in_data;
            end else begin
                vld[i] <= vld[i-1];
                if (vld[i-1]) dat[i] <= dat[i-1];
            end
        end
    end

    assign out_valid = vld[DEPTH-1];
    assign out_data  = dat[DEPTH-1];
endmodule

// File: rtl/csd_xsinx_fir.sv
module csd_xsinx_fir
    import fir_pkg::*;
#(
    parameter int IN_W     = 14,
    parameter int NTAPS    = 11,
    parameter int LATENCY  = 9,
    parameter int SH_OUTER = 9,
    parameter int SH_INNER = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IN_W-1:0]   in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sum,
    output logic [DATA_W-1:0] out_carry
);
    localparam int EXT = DATA_W - IN_W;

    logic     accept;
    word_t    x_word;
    cs_pair_t acc_q    [NTAPS];
    cs_pair_t chain_in [NTAPS];
    cs_pair_t tap_nxt  [NTAPS];
    logic     head_valid;
    cs_pair_t out_pair;

    assign in_ready = ~rst;
    assign accept   = in_valid & in_ready;
    assign x_word   = {{EXT{in_sample[IN_W-1]}}, in_sample};

    always_comb begin
        for (int k = 0; k < NTAPS - 1; k++) chain_in[k] = acc_q[k+1];
        chain_in[NTAPS-1] = '0;
    end

    generate
        for (genvar k = 0; k < NTAPS; k++) begin : g_tap
            localparam term_t TA = coef_term(k, 0, SH_OUTER, SH_INNER);
            localparam term_t TB = coef_term(k, 1, SH_OUTER, SH_INNER);
            csd_tap #(.TERM_A(TA), .TERM_B(TB)) u_tap (
                .x_word (x_word),
                .acc_in (chain_in[k]),
                .acc_out(tap_nxt[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NTAPS; k++) acc_q[k] <= '0;
            head_valid <= 1'b0;
        end else begin
            if (accept)
                for (int k = 0; k < NTAPS; k++) acc_q[k] <= tap_nxt[k];
            head_valid <= accept;
        end
    end

    fir_out_pipe #(.DEPTH(LATENCY - 1)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .in_valid (head_valid),
        .in_data  (acc_q[0]),
        .out_valid(out_valid),
        .out_data (out_pair)
    );

    assign out_sum   = out_pair.s;
    assign out_carry = out_pair.c;
endmodule

// File: rtl/csd_fir_chk.sv
module csd_fir_chk
    import fir_pkg::*;
#(
    parameter int LATENCY = 9
) (
    input logic     clk,
    input logic     rst,
    input logic     in_valid,
    input logic     in_ready,
    input logic     out_valid,
    input word_t    out_sum,
    input word_t    out_carry,
    input cs_pair_t head_pair
);
    logic [LATENCY-1:0] acc_hist;

    always_ff @(posedge clk) begin
        if (rst) acc_hist <= '0;
        else     acc_hist <= {acc_hist[LATENCY-2:0], in_valid & in_ready};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == acc_hist[LATENCY-1]);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(head_pair));

    // R7
    known_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown({out_sum, out_carry}));
endmodule

bind csd_xsinx_fir csd_fir_chk #(.LATENCY(LATENCY)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_sum  (out_sum),
    .out_carry(out_carry),
    .head_pair(acc_q[0])
);

// File: tb/csd_xsinx_fir_bench.sv
module csd_xsinx_fir_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [13:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sum, out_carry;

    always #2 clk = ~clk;

    csd_xsinx_fir u_csd_xsinx_fir (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .out_valid(out_valid),
        .out_sum(out_sum), .out_carry(out_carry)
    );

    int checks = 0, fails = 0, cyc = 0;
    int wr = 0, rd = 0;
    int          due   [1024];
    logic [15:0] exp_y [1024];
    string       tagq  [1024];
    logic [13:0] hist  [11];
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // bench coefficient table (R4): shift, sign, enable for two terms
    function automatic logic [15:0] term_val(logic [13:0] x, int sh, bit neg);
        logic signed [15:0] xs;
        xs = {{2{x[13]}}, x};
        xs = xs >>> sh;
        return neg ? -xs : xs;
    endfunction

    function automatic logic [15:0] tap_val(int k, logic [13:0] x);
        int m;
        m = (k > 5) ? 10 - k : k;
        case (m)
            0: return term_val(x, 9, 1);
            1: return term_val(x, 8, 0);
            2: return term_val(x, 7, 1);
            3: return term_val(x, 6, 0) + term_val(x, 8, 0);
            4: return term_val(x, 4, 1) + term_val(x, 8, 0);
            default: return term_val(x, 0, 0) + term_val(x, 2, 0);
        endcase
    endfunction

    function automatic logic [15:0] ref_y();
        logic [15:0] acc;
        acc = '0;
        for (int k = 0; k < 11; k++) acc += tap_val(k, hist[k]);
        return acc;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [13:0] x, string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = x;
        for (int k = 10; k > 0; k--) hist[k] = hist[k-1];
        hist[0]   = x;
        exp_y[wr] = ref_y();
        due[wr]   = cyc + 1 + 8;
        tagq[wr]  = tag;
        wr++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // output monitor: each result due at the negedge after acceptance edge + 8
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (rd < wr && due[rd] == cyc) begin
                    check(out_valid === 1'b1, "R2 out_valid at due cycle", 32'(out_valid), 1);
                    check(16'(out_sum + out_carry) === exp_y[rd], tagq[rd],
                          32'(16'(out_sum + out_carry)), 32'(exp_y[rd]));
                    rd++;
                end else if (out_valid) begin
                    check(1'b0, "R2 unexpected out_valid", 1, 0);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int k = 0; k < 11; k++) hist[k] = '0;
        repeat (3) begin
            @(negedge clk);
            check(in_ready === 1'b0, "R1 ready in reset", 32'(in_ready), 0);
            check(out_valid === 1'b0, "R1 out_valid in reset", 32'(out_valid), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 ready after reset", 32'(in_ready), 1);
        // R4 positive impulse, large enough to expose every shift
        send(14'd4096, "R4 impulse");
        for (int i = 0; i < 11; i++) send(14'd0, "R4 impulse tail");
        // R6 negative full scale impulse
        send(14'h2000, "R6 neg full scale");
        for (int i = 0; i < 11; i++) send(14'd0, "R6 tail");
        // R3 positive step
        for (int i = 0; i < 14; i++) send(14'd8191, "R3 step");
        idle(12);
        // R5 samples separated by idle gaps
        for (int i = 0; i < 20; i++) begin
            send(14'($urandom), "R5 gapped");
            idle(1 + ($urandom % 4));
        end
        // R7 back-to-back random
        for (int i = 0; i < 150; i++) send(14'($urandom), "R7 random");
        idle(14);
        check(rd == wr, "R2 all results delivered", 32'(rd), 32'(wr));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule